// File: doc/BRIEF.md
# Pad Standby State Override

This block is a per-pad output stage that sits between the ordinary pad control logic and the pad buffers. Each pad has a transmit value, a transmit enable and a raw pad input. In normal operation these pass straight through. One standby request is shared by all pads, and each pad has its own 4-bit standby-state code. While the request is active, the code of each pad decides four things: whether its transmitter is forced to a constant, holds the value it was driving when standby began, or is tri-stated; and whether its receiver keeps delivering the pad input or hands a forced constant back to the internal logic.

The request is registered. Standby therefore begins on the clock edge at which the request is first seen high, and it ends on the edge at which the request is first seen low. On the entry edge, each pad samples its normal transmit value into a hold register. That register stays frozen for the whole standby period, so a pad using the hold code keeps driving the same level even though the normal logic behind it goes on changing. Codes with no defined meaning leave the pad fully normal, as the explicit ignore code does.

Top module: `pad_stby_override`

## Requirements
- R1: While reset (rst_n low) is asserted, the override is inactive whatever the request and codes are: pad_out equals tx_val, pad_oe equals tx_en and rx_val equals pad_in.
- R2: The override takes effect on the first rising clock edge at which stby_req is sampled high. It releases on the first rising edge at which stby_req is sampled low. Between those edges the outputs follow the earlier state.
- R3: Code 0: pad_oe is 1 and pad_out is the tx_val sampled on the entry edge, held while the override lasts even if tx_val changes; rx_val equals pad_in.
- R4: Codes 1 to 4 set pad_oe to 1 and drive a constant, 0 for codes 1 and 2 and 1 for codes 3 and 4. rx_val is forced to 0 for codes 1 and 3 and to 1 for codes 2 and 4, whatever pad_in is.
- R5: Codes 5 and 6 set pad_oe to 1 and drive 0 (code 5) or 1 (code 6); rx_val equals pad_in.
- R6: Codes 7 and 8 set pad_oe to 0 and pad_out to 0; rx_val is forced to 0 (code 7) or 1 (code 8).
- R7: Code 9 sets pad_oe to 0 and pad_out to 0; rx_val equals pad_in.
- R8: Codes 10 to 15 have no effect: under an active override the pad behaves exactly as in normal operation.
- R9: With the override inactive, every pad passes through: pad_out = tx_val, pad_oe = tx_en, rx_val = pad_in.
- R10: Each pad obeys only its own code, in bits [4*i+3:4*i] of stby_code, together with its own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby request, shared by all pads |
| tx_val | input | NUM_PADS | Normal transmit value per pad |
| tx_en | input | NUM_PADS | Normal transmit enable per pad |
| pad_in | input | NUM_PADS | Raw pad receiver input per pad |
| stby_code | input | 4*NUM_PADS | Standby-state code per pad, pad i in bits [4i+3:4i] |
| pad_out | output | NUM_PADS | Value driven onto the pad |
| pad_oe | output | NUM_PADS | Pad output buffer enable |
| rx_val | output | NUM_PADS | Receive value returned to internal logic |

## Verification
On every cycle the assertions check the per-code output rules against a registered copy of the request: the forced drive and return constants, the tri-state codes, the undefined and ignore codes, and pass-through while no standby is in force. They also check that the held drive level stays unchanged over consecutive hold-code cycles. Only the bench scenarios can show that the held level is the one present on the entry edge, and that entry and exit fall on the right edges while the request is changing. For these scenarios the bench moves tx_val, tx_en and pad_in after entry and sweeps all sixteen codes with a different code on each pad.

// File: rtl/pad_stby_pkg.sv
package pad_stby_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      STBY_HOLD_RXON   = 4'd0,
      STBY_D0_R0       = 4'd1,
      STBY_D0_R1       = 4'd2,
      STBY_D1_R0       = 4'd3,
      STBY_D1_R1       = 4'd4,
      STBY_D0_RXON     = 4'd5,
      STBY_D1_RXON     = 4'd6,
      STBY_HIZ_R0      = 4'd7,
      STBY_HIZ_R1      = 4'd8,
      STBY_TXOFF_RXON  = 4'd9,
      STBY_IGNORE      = 4'd15
   } stby_code_e;

   // Decoded action for one pad
   typedef struct packed {
      logic tx_take;    // transmitter owned by the override
      logic tx_hold;    // drive the captured level
      logic tx_on;      // output buffer enabled
      logic tx_level;   // constant drive level
      logic rx_take;    // receive path forced
      logic rx_level;   // forced receive level
   } stby_act_t;

endpackage

// File: rtl/pad_stby_decode.sv
module pad_stby_decode
   import pad_stby_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output stby_act_t         act
);

   always_comb begin
      act = '0;
      case (code)
         STBY_HOLD_RXON: begin
            act.tx_take = 1'b1;
            act.tx_hold = 1'b1;
            act.tx_on   = 1'b1;
         end
         STBY_D0_R0, STBY_D0_R1, STBY_D1_R0, STBY_D1_R1: begin
            act.tx_take  = 1'b1;
            act.tx_on    = 1'b1;
            act.tx_level = (code == STBY_D1_R0) || (code == STBY_D1_R1);
            act.rx_take  = 1'b1;
            act.rx_level = (code == STBY_D0_R1) || (code == STBY_D1_R1);
         end
         STBY_D0_RXON, STBY_D1_RXON: begin
            act.tx_take  = 1'b1;
            act.tx_on    = 1'b1;
            act.tx_level = (code == STBY_D1_RXON);
         end
         STBY_HIZ_R0, STBY_HIZ_R1: begin
            act.tx_take  = 1'b1;
            act.rx_take  = 1'b1;
            act.rx_level = (code == STBY_HIZ_R1);
         end
         STBY_TXOFF_RXON: begin
            act.tx_take = 1'b1;
         end
         default: act = '0;   // undefined codes and ignore
      endcase
   end

endmodule

// File: rtl/pad_stby_slice.sv
module pad_stby_slice
   import pad_stby_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              entry,     // standby entry edge
   input  logic              ovr_on,    // override in force
   input  logic [CODE_W-1:0] code,
   input  logic              tx_val,
   input  logic              tx_en,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              rx_val
);

   stby_act_t act;
   logic      held_q;

   pad_stby_decode u_dec (
      .code (code),
      .act  (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held_q <= 1'b0;
      else if (entry) held_q <= tx_val;
   end

   always_comb begin
      if (ovr_on && act.tx_take) begin
         pad_oe  = act.tx_on;
         pad_out = act.tx_on & (act.tx_hold ? held_q : act.tx_level);
      end else begin
         pad_oe  = tx_en;
         pad_out = tx_val;
      end
      rx_val = (ovr_on && act.rx_take) ? act.rx_level : pad_in;
   end

endmodule

// File: rtl/pad_stby_override.sv
module pad_stby_override
   import pad_stby_pkg::*;
#(
   parameter int NUM_PADS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stby_req,
   input  logic [NUM_PADS-1:0]        tx_val,
   input  logic [NUM_PADS-1:0]        tx_en,
   input  logic [NUM_PADS-1:0]        pad_in,
   input  logic [NUM_PADS*CODE_W-1:0] stby_code,
   output logic [NUM_PADS-1:0]        pad_out,
   output logic [NUM_PADS-1:0]        pad_oe,
   output logic [NUM_PADS-1:0]        rx_val
);

   localparam int CODE_BITS = NUM_PADS * CODE_W;

   if (NUM_PADS < 1) begin : g_bad_pads
      $error("pad_stby_override: NUM_PADS must be at least 1");
   end
   if (CODE_BITS != $bits(stby_code)) begin : g_bad_code
      $error("pad_stby_override: code bus width mismatch");
   end

   logic req_q;
   logic entry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= stby_req;
   end

   assign entry = stby_req & ~req_q;

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      pad_stby_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .entry   (entry),
         .ovr_on  (req_q),
         .code    (stby_code[p*CODE_W +: CODE_W]),
         .tx_val  (tx_val[p]),
         .tx_en   (tx_en[p]),
         .pad_in  (pad_in[p]),
         .pad_out (pad_out[p]),
         .pad_oe  (pad_oe[p]),
         .rx_val  (rx_val[p])
      );
   end

endmodule

// File: rtl/pad_stby_chk.sv
module pad_stby_chk #(
   parameter int NUM_PADS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  stby_req,
   input logic [NUM_PADS-1:0]   tx_val,
   input logic [NUM_PADS-1:0]   tx_en,
   input logic [NUM_PADS-1:0]   pad_in,
   input logic [NUM_PADS*4-1:0] stby_code,
   input logic [NUM_PADS-1:0]   pad_out,
   input logic [NUM_PADS-1:0]   pad_oe,
   input logic [NUM_PADS-1:0]   rx_val
);

   logic seen_q;
   logic hold_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= stby_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_run_q <= 1'b0;
      else        hold_run_q <= seen_q;
   end

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
      logic [3:0] c;
      assign c = stby_code[p*4 +: 4];

      // R9
      passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !seen_q |-> (pad_out[p] == tx_val[p] && pad_oe[p] == tx_en[p] && rx_val[p] == pad_in[p]));

      // R4
      fixed_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && c >= 4'd1 && c <= 4'd4) |->
            (pad_oe[p] && pad_out[p] == (c >= 4'd3) && rx_val[p] == (c == 4'd2 || c == 4'd4)));

      // R5
      fixed_rxon_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && (c == 4'd5 || c == 4'd6)) |->
            (pad_oe[p] && pad_out[p] == (c == 4'd6) && rx_val[p] == pad_in[p]));

      // R6
      hiz_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && (c == 4'd7 || c == 4'd8)) |->
            (!pad_oe[p] && !pad_out[p] && rx_val[p] == (c == 4'd8)));

      // R7
      txoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && c == 4'd9) |-> (!pad_oe[p] && !pad_out[p] && rx_val[p] == pad_in[p]));

      // R8
      ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && c >= 4'd10) |->
            (pad_out[p] == tx_val[p] && pad_oe[p] == tx_en[p] && rx_val[p] == pad_in[p]));

      // R3
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && hold_run_q && c == 4'd0 && $past(c) == 4'd0) |->
            (pad_oe[p] && $stable(pad_out[p]) && rx_val[p] == pad_in[p]));
   end

endmodule

bind pad_stby_override pad_stby_chk #(.NUM_PADS(NUM_PADS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stby_req  (stby_req),
   .tx_val    (tx_val),
   .tx_en     (tx_en),
   .pad_in    (pad_in),
   .stby_code (stby_code),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .rx_val    (rx_val)
);

// File: tb/pad_stby_override_test.sv
module pad_stby_override_test;

   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           stby_req = 1'b0;
   logic [N-1:0]   tx_val = '0;
   logic [N-1:0]   tx_en = '0;
   logic [N-1:0]   pad_in = '0;
   logic [N*4-1:0] stby_code = '0;
   logic [N-1:0]   pad_out;
   logic [N-1:0]   pad_oe;
   logic [N-1:0]   rx_val;

   logic [N-1:0]   held_m;
   int             n_run = 0;
   int             n_fail = 0;

   always #10 clk = ~clk;

   pad_stby_override #(.NUM_PADS(N)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby_req  (stby_req),
      .tx_val    (tx_val),
      .tx_en     (tx_en),
      .pad_in    (pad_in),
      .stby_code (stby_code),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .rx_val    (rx_val)
   );

   // expected {out, oe, rx} from the requirements
   function automatic logic [2:0] expect_pad(input logic act, input logic [3:0] c,
                                             input logic held, input logic tx,
                                             input logic en, input logic pin);
      if (!act) return {tx, en, pin};
      case (c)
         4'd0:    return {held, 1'b1, pin};
         4'd1:    return 3'b010;
         4'd2:    return 3'b011;
         4'd3:    return 3'b110;
         4'd4:    return 3'b111;
         4'd5:    return {2'b01, pin};
         4'd6:    return {2'b11, pin};
         4'd7:    return 3'b000;
         4'd8:    return 3'b001;
         4'd9:    return {2'b00, pin};
         default: return {tx, en, pin};
      endcase
   endfunction

   task automatic check_all(input logic act, input string req);
      for (int p = 0; p < N; p++) begin
         logic [2:0] e, a;
         e = expect_pad(act, stby_code[p*4 +: 4], held_m[p], tx_val[p], tx_en[p], pad_in[p]);
         a = {pad_out[p], pad_oe[p], rx_val[p]};
         n_run++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s pad %0d code %0d: got {out,oe,rx}=%b expected %b",
                     req, p, stby_code[p*4 +: 4], a, e);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: request and hiz codes during reset must not act
      stby_req = 1'b1;
      for (int p = 0; p < N; p++) stby_code[p*4 +: 4] = 4'd7;
      tx_val = 4'b1010; tx_en = 4'b0110; pad_in = 4'b1100;
      held_m = '0;
      repeat (3) @(negedge clk);
      #4 check_all(1'b0, "R1");
      stby_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #4 check_all(1'b0, "R9");

      for (int c = 0; c < 16; c++) begin
         for (int pat = 0; pat < 4; pat++) begin
            logic [N-1:0] a_tx, a_en, a_in;
            a_tx = {N{pat[0]}} ^ 4'b0101;
            a_en = {N{pat[1]}} ^ 4'b0011;
            a_in = {N{pat[0] ^ pat[1]}} ^ 4'b1001;
            @(negedge clk);
            stby_req = 1'b0;
            for (int p = 0; p < N; p++) stby_code[p*4 +: 4] = 4'((c + p * 5) % 16);   // R10
            tx_val = a_tx; tx_en = a_en; pad_in = a_in;
            #4 check_all(1'b0, "R9");
            // request rises; not yet sampled
            @(negedge clk);
            stby_req = 1'b1;
            #4 check_all(1'b0, "R2");
            @(posedge clk);
            held_m = tx_val;
            // normal logic moves after entry
            @(negedge clk);
            tx_val = ~a_tx; tx_en = ~a_en; pad_in = ~a_in;
            #4 check_all(1'b1, "R3/R4/R5/R6/R7/R8/R10");
            @(negedge clk);
            tx_val = a_tx ^ 4'b0011; pad_in = a_in;
            #4 check_all(1'b1, "R3");
            // request falls; override remains until sampled
            @(negedge clk);
            stby_req = 1'b0;
            #4 check_all(1'b1, "R2");
            @(negedge clk);
            #4 check_all(1'b0, "R2");
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule